// File: doc/BRIEF.md
# Carry-less Multiplier with Half-Select

This block multiplies two 64-bit polynomials over GF(2) and returns their 128-bit product. Partial products are combined with exclusive-OR, so no carry moves between bit positions. Bit i of an operand is the coefficient of x^i. Each operand is one half of a 128-bit input word, and two bits of an 8-bit select code choose which half is used.

A caller presents both 128-bit words and the select code, and raises `in_valid` for one cycle. The product and `out_valid` come out of a single register stage on the next clock edge. The result register holds its value until the next accepted request. Reducing the product modulo a field polynomial is left to downstream logic.

Top module: `clmul_halfsel`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `out_valid` and `result` are both cleared to zero on that edge.
- R2: `out_valid` is high in exactly the cycle after `in_valid` was sampled high, and low otherwise.
- R3: Select code 0x00 multiplies `word_a[63:0]` by `word_b[63:0]`.
- R4: Select code 0x01 multiplies `word_a[127:64]` by `word_b[63:0]`.
- R5: Select code 0x10 multiplies `word_a[63:0]` by `word_b[127:64]`.
- R6: Select code 0x11 multiplies `word_a[127:64]` by `word_b[127:64]`.
- R7: Only `sel[0]` (half of `word_a`) and `sel[4]` (half of `word_b`) affect the result. Bits 1-3 and 5-7 are ignored.
- R8: `result[127]` is always zero.
- R9: If the selected `word_b` half equals 1, the result is the selected `word_a` half zero-extended to 128 bits. If either selected half is zero, the result is zero.
- R10: Swapping `word_a` with `word_b` while also swapping `sel[0]` with `sel[4]` gives the same result.
- R11: While `in_valid` is low, `result` keeps its previous value.
- R12: Partial products combine with XOR and no carry. For example, 3 times 3 gives 5, and 0xFF times 0xFF gives 0x5555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| word_a | input | 128 | First operand word |
| word_b | input | 128 | Second operand word |
| sel | input | 8 | Half-select code; bit 0 picks the half of `word_a`, bit 4 picks the half of `word_b` |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Carry-less product |

## Verification
The four select codes are each tried with words whose two halves hold different values, so that picking the wrong half shows up as a wrong result. Small known products such as 3×3=5 and 0xFF×0xFF=0x5555 tell XOR accumulation apart from ordinary addition. All-ones halves reach the top degree and show whether bit 127 stays clear.

Identity and zero operands check that operand routing is correct with no bit shift. Swapped-word requests check that the half selection is symmetric between the two words. Codes that have the ignored bits set, and idle cycles between requests, check that the select decode and the result hold do not react to anything else.

// File: rtl/clmul_halfsel.sv
module clmul_halfsel #(
  parameter int HALF_W    = 64,
  parameter int SEL_W     = 8,
  parameter int SEL_A_BIT = 0,
  parameter int SEL_B_BIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*HALF_W-1:0] word_a,
  input  logic [2*HALF_W-1:0] word_b,
  input  logic [SEL_W-1:0]    sel,
  output logic                out_valid,
  output logic [2*HALF_W-1:0] result
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] op_a, op_b;
  logic [WORD_W-1:0] prod;

  assign op_a = sel[SEL_A_BIT] ? word_a[WORD_W-1:HALF_W] : word_a[HALF_W-1:0];
  assign op_b = sel[SEL_B_BIT] ? word_b[WORD_W-1:HALF_W] : word_b[HALF_W-1:0];

  always_comb begin
    prod = '0;
    for (int i = 0; i < HALF_W; i++)
      if (op_b[i]) prod = prod ^ ({{HALF_W{1'b0}}, op_a} << i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= prod;
    end
  end
endmodule

module clmul_halfsel_chk #(
  parameter int HALF_W    = 64,
  parameter int SEL_W     = 8,
  parameter int SEL_A_BIT = 0,
  parameter int SEL_B_BIT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2*HALF_W-1:0] word_a,
  input logic [2*HALF_W-1:0] word_b,
  input logic [SEL_W-1:0]    sel,
  input logic                out_valid,
  input logic [2*HALF_W-1:0] result
);
  logic [HALF_W-1:0] ha, hb;
  assign ha = sel[SEL_A_BIT] ? word_a[2*HALF_W-1:HALF_W] : word_a[HALF_W-1:0];
  assign hb = sel[SEL_B_BIT] ? word_b[2*HALF_W-1:HALF_W] : word_b[HALF_W-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && result == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R8
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !result[2*HALF_W-1]);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result));
  // R9
  one_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hb == HALF_W'(1)) |=> result == {{HALF_W{1'b0}}, $past(ha)});
  // R9
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (ha == '0 || hb == '0)) |=> result == '0);
endmodule

bind clmul_halfsel clmul_halfsel_chk #(
  .HALF_W(HALF_W), .SEL_W(SEL_W), .SEL_A_BIT(SEL_A_BIT), .SEL_B_BIT(SEL_B_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_a(word_a), .word_b(word_b),
  .sel(sel), .out_valid(out_valid), .result(result)
);

// File: tb/clmul_halfsel_tb.sv
module clmul_halfsel_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] word_a = '0, word_b = '0;
  logic [7:0]   sel = '0;
  logic         out_valid;
  logic [127:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  clmul_halfsel u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_a(word_a), .word_b(word_b),
    .sel(sel), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] gf2_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] acc = '0;
    for (int k = 0; k < 64; k++)
      if (y[k]) acc = acc ^ ({64'b0, x} << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [7:0] s);
    @(negedge clk);
    word_a = a; word_b = b; sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    check("R1 out_valid", {127'b0, out_valid}, 128'd0);
    check("R1 result", result, 128'd0);
  endtask

  task automatic t_halves();
    logic [127:0] a = {64'hDEAD_BEEF_0123_4567, 64'h0000_0000_0000_0007};
    logic [127:0] b = {64'h0000_0000_0000_0005, 64'hF0F0_0000_1111_0003};
    issue(a, b, 8'h00);
    check("R3 sel 00", result, gf2_mul(a[63:0], b[63:0]));
    check("R2 valid", {127'b0, out_valid}, 128'd1);
    issue(a, b, 8'h01);
    check("R4 sel 01", result, gf2_mul(a[127:64], b[63:0]));
    issue(a, b, 8'h10);
    check("R5 sel 10", result, gf2_mul(a[63:0], b[127:64]));
    issue(a, b, 8'h11);
    check("R6 sel 11", result, gf2_mul(a[127:64], b[127:64]));
    @(negedge clk);
    check("R2 idle", {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_known();
    // R12
    issue(128'd3, 128'd3, 8'h00);
    check("R12 3x3", result, 128'd5);
    issue(128'hFF, 128'hFF, 8'h00);
    check("R12 ffxff", result, 128'h5555);
  endtask

  task automatic t_ignored();
    logic [127:0] a = {64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978};
    logic [127:0] b = {64'hCAFE_F00D_0000_0001, 64'h8000_0000_0000_0003};
    // R7
    issue(a, b, 8'hEE);
    check("R7 sel ee", result, gf2_mul(a[63:0], b[63:0]));
    issue(a, b, 8'h2D);
    check("R7 sel 2d", result, gf2_mul(a[127:64], b[63:0]));
    issue(a, b, 8'hD2);
    check("R7 sel d2", result, gf2_mul(a[63:0], b[127:64]));
  endtask

  task automatic t_top_bit();
    issue({64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 8'h11);
    // R8
    check("R8 bit127", {127'b0, result[127]}, 128'd0);
    check("R8 full", result, gf2_mul(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF));
  endtask

  task automatic t_identity();
    logic [127:0] a = {64'hA5A5_0000_FFFF_1234, 64'h8000_0000_0000_0001};
    // R9
    issue(a, {64'd1, 64'd9}, 8'h11);
    check("R9 times one", result, {64'b0, a[127:64]});
    issue(a, {64'd9, 64'd1}, 8'h00);
    check("R9 times one lo", result, {64'b0, a[63:0]});
    issue(a, {64'd0, 64'd9}, 8'h10);
    check("R9 times zero", result, 128'd0);
  endtask

  task automatic t_commute();
    logic [127:0] a = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    logic [127:0] b = {64'h1357_9BDF_0246_8ACE, 64'h0F0F_F0F0_3C3C_C3C3};
    logic [127:0] r1;
    // R10
    issue(a, b, 8'h01);
    r1 = result;
    issue(b, a, 8'h10);
    check("R10 swap 01/10", result, r1);
    issue(a, b, 8'h10);
    r1 = result;
    issue(b, a, 8'h01);
    check("R10 swap 10/01", result, r1);
  endtask

  task automatic t_hold();
    logic [127:0] r1;
    issue(128'd7, 128'd6, 8'h00);
    r1 = result;
    @(negedge clk);
    word_a = '1; word_b = '1; sel = 8'h11;
    repeat (3) @(negedge clk);
    // R11
    check("R11 hold", result, r1);
    check("R11 value", r1, 128'd18);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_halves();
    t_known();
    t_ignored();
    t_top_bit();
    t_identity();
    t_commute();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule